// File: doc/BRIEF.md
# Habituating Threshold Wakeup Controller

This block stays powered while the rest of the system sleeps. It watches several sensor channels in parallel, such as shock, vibration, light, tilt, magnetic field and radio query. Each channel presents a digitized magnitude together with a per-cycle valid strobe. A sample counts as a qualifying event when it is valid, when its channel is enabled, and when its magnitude is equal to or greater than that channel's current effective threshold. A qualifying event sets that channel's bit in a sticky cause vector. The wake request is the OR of the cause bits, so it stays high until the host acknowledges it.

The block habituates so that a channel that keeps firing does not keep waking the system for the same stimulus. Each qualifying event raises the channel's effective threshold by a programmable step, up to a programmable ceiling. After a programmable run of cycles with no qualifying event, the threshold relaxes by one step, and it never drops below the channel's base value. The per-channel base thresholds, the step, the ceiling, the quiet interval and the channel enable mask are all set through a simple register write port.

Top module: `wake_habituate`

## Requirements
- R1: After reset, wake_req is 0 and wake_cause is all zeros. Every channel is enabled. Every base and effective threshold is DEF_BASE (32), the step is DEF_STEP (16), the ceiling is DEF_CEIL (200) and the quiet interval is DEF_QUIET (100).
- R2: Channel i has a qualifying event in a cycle when stim_vld[i] is 1, its enable bit is 1, and stim_mag[i*MW +: MW] is greater than or equal to its effective threshold. The event sets wake_cause[i] at the next clock edge. A magnitude one below the threshold sets nothing.
- R3: wake_req equals the OR of wake_cause. Cause bits from events on later cycles accumulate, and no cause bit clears while wake_ack is 0.
- R4: A cycle with wake_ack at 1 replaces the cause vector with that cycle's qualifying events, so with no events the vector becomes zero.
- R5: A channel whose enable bit is 0 never sets its cause bit, and its samples leave its effective threshold unchanged.
- R6: On a qualifying event, the effective threshold becomes min(threshold + step, ceiling). A threshold already at or above the ceiling stays as it is.
- R7: Each channel counts consecutive cycles without a qualifying event. When the count reaches the quiet interval, the count restarts and the threshold drops by the step, floored at the channel's base. A quiet interval of 0 turns relaxation off.
- R8: When cfg_we is 1, cfg_addr selects the register to write. Addresses 0 to NCH-1 write that channel's base threshold from cfg_wdata[MW-1:0], and the same write loads it as the effective threshold. Address NCH writes the step from [MW-1:0], NCH+1 the ceiling from [MW-1:0], NCH+2 the quiet interval from [QW-1:0], and NCH+3 the enable mask from [NCH-1:0], where bit i enables channel i. The evaluation in the cycle of a write still uses the old values.
- R9: Channels are evaluated at the same time and independently, so events on several channels in one cycle set all their cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stim_vld | input | NCH | Per-channel sample valid |
| stim_mag | input | NCH*MW | Packed per-channel magnitudes, channel i at [i*MW +: MW] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register select |
| cfg_wdata | input | DW | Configuration write data |
| wake_ack | input | 1 | Host acknowledge, clears the cause vector |
| wake_req | output | 1 | Wake request to the host |
| wake_cause | output | NCH | Channels that caused the pending wake |

## Verification
The properties on threshold movement assume that no configuration write happens in the checked cycle, because a base write may lower the threshold and a ceiling write may change the saturation point. Those properties are therefore qualified on cfg_we being low. The acknowledge property assumes wake_ack is a level sampled on each edge, not a pulse shorter than a cycle. The bench drives every input at the falling edge and holds it for a whole cycle, and it keeps configuration writes to single-cycle strobes. This lets the properties and the reference model see the same values.

// File: rtl/wake_habituate.sv
module wake_habituate #(
  parameter int NCH       = 4,
  parameter int MW        = 8,
  parameter int QW        = 12,
  parameter int DEF_BASE  = 32,
  parameter int DEF_STEP  = 16,
  parameter int DEF_CEIL  = 200,
  parameter int DEF_QUIET = 100,
  localparam int AW = $clog2(NCH + 4),
  localparam int DW = (QW > MW) ? ((QW > NCH) ? QW : NCH) : ((MW > NCH) ? MW : NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    stim_vld,
  input  logic [NCH*MW-1:0] stim_mag,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              wake_ack,
  output logic              wake_req,
  output logic [NCH-1:0]    wake_cause
);

  logic [NCH-1:0][MW-1:0] base_q, eff_q;
  logic [MW-1:0]          step_q, ceil_q;
  logic [QW-1:0]          quiet_q;
  logic [NCH-1:0]         en_q, cause_q, ev;

  wire wr_step  = cfg_we && cfg_addr == AW'(NCH);
  wire wr_ceil  = cfg_we && cfg_addr == AW'(NCH + 1);
  wire wr_quiet = cfg_we && cfg_addr == AW'(NCH + 2);
  wire wr_mask  = cfg_we && cfg_addr == AW'(NCH + 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= MW'(DEF_STEP);
      ceil_q  <= MW'(DEF_CEIL);
      quiet_q <= QW'(DEF_QUIET);
      en_q    <= '1;
    end else begin
      if (wr_step)  step_q  <= cfg_wdata[MW-1:0];
      if (wr_ceil)  ceil_q  <= cfg_wdata[MW-1:0];
      if (wr_quiet) quiet_q <= cfg_wdata[QW-1:0];
      if (wr_mask)  en_q    <= cfg_wdata[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [QW-1:0] qcnt;
    logic [MW:0]   sum;
    logic [MW-1:0] up, dn;
    logic          qwrap, wr_base;

    assign wr_base = cfg_we && cfg_addr == AW'(i);
    assign ev[i]   = stim_vld[i] && en_q[i] && (stim_mag[i*MW +: MW] >= eff_q[i]);
    assign sum     = {1'b0, eff_q[i]} + {1'b0, step_q};
    assign up      = (eff_q[i] >= ceil_q) ? eff_q[i] :
                     (sum > {1'b0, ceil_q}) ? ceil_q : sum[MW-1:0];
    assign dn      = (eff_q[i] <= base_q[i]) ? eff_q[i] :
                     ((eff_q[i] - base_q[i]) < step_q) ? base_q[i] : eff_q[i] - step_q;
    assign qwrap   = (quiet_q != '0) && (qcnt >= quiet_q - QW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= MW'(DEF_BASE);
        eff_q[i]  <= MW'(DEF_BASE);
        qcnt      <= '0;
      end else begin
        if (ev[i] || qwrap || quiet_q == '0) qcnt <= '0;
        else                                  qcnt <= qcnt + QW'(1);
        if (wr_base) begin
          base_q[i] <= cfg_wdata[MW-1:0];
          eff_q[i]  <= cfg_wdata[MW-1:0];
        end else if (ev[i]) begin
          eff_q[i]  <= up;
        end else if (qwrap) begin
          eff_q[i]  <= dn;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= '0;
    else if (wake_ack) cause_q <= ev;
    else               cause_q <= cause_q | ev;
  end

  assign wake_cause = cause_q;
  assign wake_req   = |cause_q;

endmodule

module wake_habituate_chk #(
  parameter int NCH = 4,
  parameter int MW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         stim_vld,
  input logic                   cfg_we,
  input logic                   wake_ack,
  input logic [NCH-1:0]         wake_cause,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0]         ev,
  input logic [NCH-1:0][MW-1:0] eff_q,
  input logic [NCH-1:0][MW-1:0] base_q
);

  // R3
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_ack |=> ((wake_cause & $past(wake_cause)) == $past(wake_cause)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ack && (stim_vld & en_q) == '0) |=> wake_cause == '0);

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wake_cause & ~($past(wake_cause) & ~{NCH{$past(wake_ack)}}))
              & ~($past(en_q) & $past(stim_vld))) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> wake_cause[i]);
    // R6
    raise_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && !cfg_we) |=> eff_q[i] >= $past(eff_q[i]));
    // R7
    relax_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev[i] && !cfg_we) |=> (eff_q[i] <= $past(eff_q[i])) &&
        (eff_q[i] == $past(eff_q[i]) || eff_q[i] >= $past(base_q[i])));
  end

endmodule

bind wake_habituate wake_habituate_chk #(.NCH(NCH), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stim_vld(stim_vld), .cfg_we(cfg_we),
  .wake_ack(wake_ack), .wake_cause(wake_cause), .en_q(en_q), .ev(ev),
  .eff_q(eff_q), .base_q(base_q)
);

// File: tb/wake_habituate_bench.sv
module wake_habituate_bench;
  localparam int NCH = 4, MW = 8, QW = 12, AW = 3, DW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    stim_vld = '0;
  logic [NCH*MW-1:0] stim_mag = '0;
  logic              cfg_we = 1'b0;
  logic [AW-1:0]     cfg_addr = '0;
  logic [DW-1:0]     cfg_wdata = '0;
  logic              wake_ack = 1'b0;
  logic              wake_req;
  logic [NCH-1:0]    wake_cause;

  always #4 clk = ~clk;

  wake_habituate u_wake_habituate (
    .clk(clk), .rst_n(rst_n), .stim_vld(stim_vld), .stim_mag(stim_mag),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wake_ack(wake_ack), .wake_req(wake_req), .wake_cause(wake_cause)
  );

  int m_thr[NCH], m_base[NCH], m_q[NCH];
  int m_step = 16, m_ceil = 200, m_quiet = 100;
  bit [NCH-1:0] m_en = '1, m_cause = '0;
  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic model_step();
    bit [NCH-1:0] ev;
    int nthr[NCH];
    for (int c = 0; c < NCH; c++) begin
      int mag = int'(stim_mag[c*MW +: MW]);
      bit wrap;
      ev[c] = stim_vld[c] && m_en[c] && mag >= m_thr[c];
      wrap = (m_quiet != 0) && (m_q[c] >= m_quiet - 1);
      nthr[c] = m_thr[c];
      if (ev[c]) begin
        if (m_thr[c] < m_ceil) nthr[c] = (m_thr[c] + m_step > m_ceil) ? m_ceil : m_thr[c] + m_step;
      end else if (wrap && m_thr[c] > m_base[c]) begin
        nthr[c] = (m_thr[c] - m_base[c] < m_step) ? m_base[c] : m_thr[c] - m_step;
      end
      m_q[c] = (ev[c] || wrap || m_quiet == 0) ? 0 : m_q[c] + 1;
      if (cfg_we && int'(cfg_addr) == c) begin
        m_base[c] = int'(cfg_wdata[MW-1:0]);
        nthr[c] = m_base[c];
      end
    end
    for (int c = 0; c < NCH; c++) m_thr[c] = nthr[c];
    if (cfg_we) begin
      if (int'(cfg_addr) == NCH)     m_step  = int'(cfg_wdata[MW-1:0]);
      if (int'(cfg_addr) == NCH + 1) m_ceil  = int'(cfg_wdata[MW-1:0]);
      if (int'(cfg_addr) == NCH + 2) m_quiet = int'(cfg_wdata[QW-1:0]);
      if (int'(cfg_addr) == NCH + 3) m_en    = cfg_wdata[NCH-1:0];
    end
    m_cause = wake_ack ? ev : (m_cause | ev);
  endtask

  task automatic compare();
    n_cmp++;
    if (wake_req !== (|m_cause) || wake_cause !== m_cause) begin
      n_bad++;
      $display("FAIL %s: req=%0b cause=%b expected req=%0b cause=%b",
               cur_req, wake_req, wake_cause, |m_cause, m_cause);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic stim(int c, int mag);
    stim_vld[c] = 1'b1;
    stim_mag[c*MW +: MW] = MW'(mag);
  endtask

  task automatic idle();
    stim_vld = '0; wake_ack = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic ack();
    wake_ack = 1'b1; cyc(); wake_ack = 1'b0;
  endtask

  task automatic cfg(int addr, int data);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = DW'(data);
    cyc();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_thr[c] = 32; m_base[c] = 32; m_q[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; compare();

    cur_req = "R2";
    stim(0, 31); cyc(); idle(); cyc();
    stim(0, 32); cyc(); idle(); cyc(2);
    ack(); cyc();

    cur_req = "R3";
    stim(1, 100); cyc(); idle(); cyc(5);
    stim(2, 100); cyc(); idle(); cyc(5);

    cur_req = "R4";
    stim(3, 200); ack(); idle(); cyc(2);
    ack(); cyc(2);

    cur_req = "R8";
    cfg(NCH + 3, 4'b1110);
    cfg(0, 40);
    cur_req = "R5";
    for (int k = 0; k < 6; k++) begin stim(0, 255); cyc(); end
    idle(); cyc();
    cfg(NCH + 3, 4'b1111);
    stim(0, 40); cyc(); idle(); cyc(); ack();

    cur_req = "R6";
    for (int k = 0; k < 14; k++) begin stim(1, 255); cyc(); idle(); cyc(); end
    stim(1, 199); cyc(); stim(1, 200); cyc(); idle(); ack(); cyc();
    cur_req = "R8";
    cfg(NCH, 7); cfg(NCH + 1, 60);
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin stim(2, 250); cyc(); end
    idle(); ack();

    cur_req = "R7";
    cfg(NCH + 2, 5);
    for (int k = 0; k < 4; k++) begin stim(3, 255); cyc(); end
    idle(); ack();
    for (int k = 0; k < 8; k++) begin cyc(4); stim(3, 40); cyc(); idle(); ack(); end
    cfg(NCH + 2, 0);
    stim(0, 255); cyc(); stim(0, 255); cyc(); idle(); ack(); cyc(40);
    stim(0, 54); cyc(); idle(); cyc(); ack();

    cur_req = "R9";
    cfg(NCH + 2, 9); cfg(NCH + 1, 180); cfg(NCH, 12);
    stim(0, 255); stim(1, 10); stim(2, 255); stim(3, 255); cyc(); idle(); cyc(); ack();
    for (int k = 0; k < 3000; k++) begin
      stim_vld  = NCH'($urandom);
      stim_mag  = ($urandom);
      wake_ack  = ($urandom % 8) == 0;
      cfg_we    = ($urandom % 50) == 0;
      cfg_addr  = AW'($urandom % (NCH + 3));
      cfg_wdata = DW'($urandom % 64 + 8);
      cyc();
    end
    idle(); cyc(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule